// File: doc/BRIEF.md
# Coherent Snapshot Cascaded Event Counter

This block counts rising edges of a slow external count input. It runs from a fast system clock. The 16-bit count is held in two byte-wide slices. The low slice passes a carry when counting up, or a borrow when counting down, to the high slice. Both slices are registered on the same clock edge, so the counter is fully synchronous. An up/down control picks the direction of each step. A load input replaces the whole count with a preset value in one cycle.

A host reads the count over a byte-wide register port that uses simple access strobes. An access to the capture address copies the full 16-bit count into a small snapshot FIFO in a single cycle. The host then reads the low byte of the oldest snapshot, and reads the high byte to remove that snapshot. Both bytes come from one register in one cycle. A capture that lands on the same edge as a low-byte rollover therefore always returns either the old value or the new value, never a mix of the two. A status address reports whether the FIFO is empty and whether a capture was lost.

Top module: `cascade_snap_counter`

## Requirements
- R1: While rst_n is low and right after it is released, the count is 0, the snapshot FIFO is empty, the overflow flag is clear and rd_data is 0. A status read then returns 0x01.
- R2: cnt_in passes through a two-stage synchronizer and a rising-edge detector. Each rising edge of cnt_in causes exactly one count step: +1 when up_dn is 1 and -1 when up_dn is 0. The step is registered on the third rising clock edge after cnt_in goes high.
- R3: A carry out of the low slice (up from 0xFF) or a borrow out of it (down from 0x00) steps the high slice on the same edge. The full 16-bit count wraps modulo 65536.
- R4: An access with acc_addr = 0 stores into the FIFO the full 16-bit count held just before that clock edge. Both bytes are stored in the same cycle. A capture on the edge where the count steps returns the pre-step value. A capture one cycle later returns the post-step value. It never returns a mix of bytes from the two values.
- R5: Reads return their data on rd_data one clock after the access, and rd_data holds that value until the next access. acc_addr = 1 returns the low byte of the oldest snapshot and leaves the snapshot in place. acc_addr = 2 returns its high byte and removes the snapshot.
- R6: When the FIFO is empty, reads of acc_addr = 1 and acc_addr = 2 return 0 and change nothing. Status bit 0 is 1 exactly when the FIFO is empty.
- R7: The FIFO holds two snapshots and returns them oldest first. A capture while it is full is dropped, leaves the stored snapshots unchanged, and sets status bit 1 (overflow).
- R8: The overflow flag stays set until a status read (acc_addr = 3). That read returns the flag still set and clears it for later reads.
- R9: When load is high, the count takes the value of preset on that clock edge. Load takes priority over a count step on the same edge.
- R10: An access to the capture address returns 0 on rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_in | input | 1 | Asynchronous count input, counted on rising edges |
| up_dn | input | 1 | Count direction: 1 up, 0 down |
| load | input | 1 | Load the count from preset |
| preset | input | 16 | Value taken by the count on load |
| acc_en | input | 1 | Host access strobe, one access per cycle |
| acc_addr | input | 2 | Host address: 0 capture, 1 low byte, 2 high byte and pop, 3 status |
| rd_data | output | 8 | Registered host read data |

## Verification
The assertions check the following on every cycle:
- the edge detector never produces two step pulses in a row;
- each step or load moves the combined 16-bit count by exactly the expected amount;
- a slice with no load and no incoming step holds its value;
- the FIFO stores exactly the word presented on a push and never exceeds its depth;
- the overflow flag stays set until a status read.

Only the bench's scenarios can show the cycle-exact capture timing around a rollover, where the result flips from the pre-step to the post-step value. The same holds for FIFO ordering across several captures, the drop-on-full behaviour seen through the status and data reads, and load winning over a simultaneous step.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  localparam int NUM_SLICES = 2;

  typedef enum logic [1:0] {
    ADDR_CAPTURE = 2'd0,
    ADDR_LOW     = 2'd1,
    ADDR_HIGH    = 2'd2,
    ADDR_STATUS  = 2'd3
  } host_addr_e;

  localparam int ST_EMPTY_BIT = 0;
  localparam int ST_OVF_BIT   = 1;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // sh[0..STAGES-1]: synchronizer chain, sh[STAGES]: previous synchronized value
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R2: one input edge never yields two consecutive step pulses
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         step_in,
  input  logic         up,
  output logic [W-1:0] q,
  output logic         step_out
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_r;
    if (ld_en)        q_d = ld_val;
    else if (step_in) q_d = up ? q_r + W'(1) : q_r - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q        = q_r;
  assign step_out = step_in & (up ? (&q_r) : ~(|q_r));

  // R3: a slice with no incoming step and no load keeps its value
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !step_in) |=> $stable(q));
endmodule

// File: rtl/snap_fifo.sv
module snap_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [OCC_W-1:0]  occ_q, occ_d;
  logic              push_ok, pop_ok;

  assign full    = (occ_q == OCC_W'(DEPTH));
  assign empty   = (occ_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign rdata   = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (push_ok) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + PTR_W'(1);
    if (pop_ok)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + PTR_W'(1);
    occ_d = occ_q + OCC_W'(push_ok) - OCC_W'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      occ_q  <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

  // R4: an accepted push stores exactly the presented word
  assert_store_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> mem[$past(wptr_q)] == $past(wdata));
  // R7: occupancy never exceeds the depth
  assert_occ_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH));
  // R7: a push into a full FIFO without a pop changes nothing
  assert_drop_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ($stable(occ_q) && $stable(wptr_q)));
endmodule

// File: rtl/cascade_snap_counter.sv
module cascade_snap_counter
  import snapcnt_pkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int FIFO_DEPTH = 2,
  parameter int SYNC_STG   = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cnt_in,
  input  logic                             up_dn,
  input  logic                             load,
  input  logic [NUM_SLICES*SLICE_W-1:0]    preset,
  input  logic                             acc_en,
  input  logic [1:0]                       acc_addr,
  output logic [SLICE_W-1:0]               rd_data
);
  localparam int CNT_W = NUM_SLICES * SLICE_W;

  logic                  step_pulse;
  logic [NUM_SLICES:0]   chain;
  logic [CNT_W-1:0]      cnt_q;
  logic [CNT_W-1:0]      head;
  logic                  fifo_full, fifo_empty;
  logic                  cap_hit, hi_hit, st_hit;
  logic                  ovf_q, ovf_d;
  logic [SLICE_W-1:0]    rd_q, rd_d;

  edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cnt_in),
    .rise  (step_pulse)
  );

  assign chain[0] = step_pulse;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    cnt_slice #(.W(SLICE_W)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (load),
      .ld_val   (preset[s*SLICE_W +: SLICE_W]),
      .step_in  (chain[s]),
      .up       (up_dn),
      .q        (cnt_q[s*SLICE_W +: SLICE_W]),
      .step_out (chain[s+1])
    );
  end

  assign cap_hit = acc_en && (acc_addr == ADDR_CAPTURE);
  assign hi_hit  = acc_en && (acc_addr == ADDR_HIGH);
  assign st_hit  = acc_en && (acc_addr == ADDR_STATUS);

  snap_fifo #(.DATA_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cap_hit),
    .pop   (hi_hit),
    .wdata (cnt_q),
    .rdata (head),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  always_comb begin
    ovf_d = ovf_q;
    if (cap_hit && fifo_full) ovf_d = 1'b1;
    else if (st_hit)          ovf_d = 1'b0;

    rd_d = rd_q;
    if (acc_en) begin
      case (acc_addr)
        ADDR_LOW:  rd_d = fifo_empty ? '0 : head[SLICE_W-1:0];
        ADDR_HIGH: rd_d = fifo_empty ? '0 : head[CNT_W-1 -: SLICE_W];
        ADDR_STATUS: begin
          rd_d = '0;
          rd_d[ST_EMPTY_BIT] = fifo_empty;
          rd_d[ST_OVF_BIT]   = ovf_q;
        end
        default:   rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      ovf_q <= ovf_d;
      rd_q  <= rd_d;
    end
  end

  assign rd_data = rd_q;

  // R2: a step without load moves the full count by one in the chosen direction
  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_pulse) && !$past(load) && $past(up_dn)) |->
      cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));
  assert_step_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_pulse) && !$past(load) && !$past(up_dn)) |->
      cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)));
  // R9: load wins over any step
  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> cnt_q == $past(preset));
  // R8: overflow flag is sticky until a status read
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovf_q) && !$past(st_hit)) |-> ovf_q);
  // R6: a data read of an empty FIFO returns zero
  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && fifo_empty && (acc_addr == ADDR_LOW || acc_addr == ADDR_HIGH))
      |=> rd_data == '0);
endmodule

// File: tb/tb_cascade_snap_counter.sv
module tb_cascade_snap_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_in, up_dn, load, acc_en;
  logic [15:0] preset;
  logic [1:0]  acc_addr;
  logic [7:0]  rd_data;
  int          n_checks = 0;
  int          n_fail   = 0;

  always #4 clk = ~clk;

  cascade_snap_counter dut (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .up_dn(up_dn), .load(load),
    .preset(preset), .acc_en(acc_en), .acc_addr(acc_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic access(input logic [1:0] a, output logic [7:0] d);
    acc_en = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    d = rd_data;
  endtask

  task automatic get_count(output logic [15:0] v);
    logic [7:0] lo, hi, z;
    access(2'd0, z);
    access(2'd1, lo);
    access(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic do_load(input logic [15:0] v);
    load = 1'b1; preset = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic pulse();
    cnt_in = 1'b1;
    repeat (4) @(negedge clk);
    cnt_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v, exp, oldv, newv;
    logic [7:0]  d, lo, hi;
    logic [15:0] cases [7];
    logic        dirs  [7];
    rst_n = 1'b0; cnt_in = 1'b0; up_dn = 1'b1; load = 1'b0;
    preset = '0; acc_en = 1'b0; acc_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", {8'h0, rd_data}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    access(2'd3, d); chk("R1 status after reset", {8'h0, d}, 16'h0001);
    get_count(v);    chk("R1 count after reset", v, 16'h0000);

    // R2/R3: up sweep across the low-byte carry
    up_dn = 1'b1; do_load(16'h00F0);
    for (int i = 1; i <= 40; i++) begin
      pulse(); get_count(v);
      chk("R2 R3 up step", v, 16'(16'h00F0 + i));
    end
    // R3: down sweep across the low-byte borrow
    up_dn = 1'b0; do_load(16'h0110);
    for (int i = 1; i <= 40; i++) begin
      pulse(); get_count(v);
      chk("R3 down step", v, 16'(16'h0110 - i));
    end
    // R3: full 16-bit wrap both ways
    up_dn = 1'b1; do_load(16'hFFFE);
    for (int i = 1; i <= 3; i++) begin
      pulse(); get_count(v); chk("R3 wrap up", v, 16'(16'hFFFE + i));
    end
    up_dn = 1'b0; do_load(16'h0001);
    for (int i = 1; i <= 3; i++) begin
      pulse(); get_count(v); chk("R3 wrap down", v, 16'(16'h0001 - i));
    end

    // R4: capture at every offset around a rollover step
    cases[0] = 16'h00FF; dirs[0] = 1'b1;
    cases[1] = 16'h0100; dirs[1] = 1'b0;
    cases[2] = 16'h0300; dirs[2] = 1'b0;
    cases[3] = 16'hFFFF; dirs[3] = 1'b1;
    cases[4] = 16'h0000; dirs[4] = 1'b0;
    cases[5] = 16'hA7FF; dirs[5] = 1'b1;
    cases[6] = 16'h1234; dirs[6] = 1'b1;
    for (int c = 0; c < 7; c++) begin
      for (int k = 1; k <= 6; k++) begin
        up_dn = dirs[c];
        oldv  = cases[c];
        newv  = dirs[c] ? 16'(oldv + 16'd1) : 16'(oldv - 16'd1);
        do_load(oldv);
        repeat (3) @(negedge clk);
        cnt_in = 1'b1;
        repeat (k - 1) @(negedge clk);
        acc_en = 1'b1; acc_addr = 2'd0;
        @(negedge clk);
        acc_en = 1'b0;
        repeat (4) @(negedge clk);
        cnt_in = 1'b0;
        repeat (4) @(negedge clk);
        access(2'd1, lo); access(2'd2, hi);
        exp = (k <= 3) ? oldv : newv;
        chk("R4 coherent capture", {hi, lo}, exp);
        get_count(v); chk("R4 count after step", v, newv);
      end
    end

    // R7/R8/R5/R10: FIFO order, drop on full, sticky overflow
    up_dn = 1'b1; do_load(16'h0A0B);
    access(2'd0, d); pulse();
    access(2'd0, d); pulse();
    access(2'd3, d); chk("R6 status two stored", {8'h0, d}, 16'h0000);
    access(2'd0, d); chk("R10 capture returns zero", {8'h0, d}, 16'h0000);
    access(2'd3, d); chk("R7 R8 overflow set", {8'h0, d}, 16'h0002);
    access(2'd3, d); chk("R8 overflow cleared", {8'h0, d}, 16'h0000);
    access(2'd1, d); chk("R5 low oldest", {8'h0, d}, 16'h000B);
    access(2'd1, d); chk("R5 low peek again", {8'h0, d}, 16'h000B);
    access(2'd2, d); chk("R5 high oldest", {8'h0, d}, 16'h000A);
    access(2'd1, d); chk("R7 second low", {8'h0, d}, 16'h000C);
    access(2'd2, d); chk("R7 second high", {8'h0, d}, 16'h000A);
    access(2'd3, d); chk("R6 status empty", {8'h0, d}, 16'h0001);
    access(2'd1, d); chk("R6 empty low", {8'h0, d}, 16'h0000);
    access(2'd3, d);
    access(2'd2, d); chk("R6 empty high", {8'h0, d}, 16'h0000);
    access(2'd3, d); chk("R6 still empty", {8'h0, d}, 16'h0001);

    // R9: load on the same edge as a step wins
    up_dn = 1'b1; do_load(16'h4000);
    repeat (3) @(negedge clk);
    cnt_in = 1'b1;
    repeat (2) @(negedge clk);
    load = 1'b1; preset = 16'h1111;
    @(negedge clk);
    load = 1'b0; preset = 16'h0000;
    repeat (4) @(negedge clk);
    cnt_in = 1'b0;
    repeat (4) @(negedge clk);
    get_count(v); chk("R9 load beats step", v, 16'h1111);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule